// File: doc/BRIEF.md
# UART Receive FIFO Time-out Detector

This block watches the receive side of a UART running with its FIFOs enabled. It raises a time-out flag when characters are left in the receive FIFO and nothing has happened for a while: the host has not read a character and the receiver has not written a new one. The wait is four full character periods. Start, data, parity and stop bits all count. The wait starts at the centre of the first stop bit of the last character, which is when the receiver issues its write pulse.

The block counts bit-clock enables. The counter restarts on any write into the receive FIFO and on any host read of the receive holding register. It is held at zero while the FIFO is empty or FIFO mode is off. When the count reaches the limit for the configured frame, a sticky flag is set. Only a host read clears it.

Top module: `rx_timeout_det`

## Requirements
- R1: While reset is asserted, `timeout` is 0.
- R2: The count advances on a `bit_tick` cycle only while `fifo_mode`=1 and `fifo_nonempty`=1. `timeout` rises at the clock edge that samples the N-th such tick after the last restart, where N is the limit in R3.
- R3: N = 4 × (1 + D + P + S). D = 5 + `char_len` (00→5 … 11→8), P = `parity_en`, and S = 1 when `stop2`=0, else 2. The 1.5-stop case of 5-bit characters is rounded up and counts as 2.
- R4: A cycle with `rd_pulse`=1 clears `timeout` at that edge.
- R5: A cycle with `wr_pulse`=1 restarts the count from zero and does not clear `timeout`.
- R6: A cycle with `rd_pulse`=1 restarts the count from zero.
- R7: While `fifo_nonempty`=0 the count is held at zero, so no number of ticks raises `timeout`.
- R8: While `fifo_mode`=0 the count is held at zero, so no number of ticks raises `timeout`.
- R9: Once set, `timeout` stays 1 through further ticks and writes until a read.
- R10: A tick in the same cycle as a write or read is not counted, because the restart takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | FIFO mode enabled |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one character |
| wr_pulse | input | 1 | New character written (centre of first stop bit) |
| rd_pulse | input | 1 | Host read of receive holding register |
| bit_tick | input | 1 | One-cycle enable per bit time |
| char_len | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Extended stop (2, or 1.5 rounded to 2) |
| timeout | output | 1 | Sticky receive time-out flag |

## Verification
A count that is off by one shows at the port: `timeout` rises one bit time early or late, which is at least one tick before or after the exact edge the reference predicts. A restart or hold that is missed shows up as a flag that appears without four quiet character times. A stuck flag shows up in the cycle after a read, when `timeout` fails to drop. A wrong limit for any frame format puts the rising edge away from 4 × (frame bits) ticks. Exercising several formats exposes this within the first expiry of each.

// File: rtl/rx_to_pkg.sv
package rx_to_pkg;
  localparam int unsigned MIN_DATA_BITS = 5;

  // Bits in one frame; a 1.5-stop setting is taken as two whole bits.
  function automatic int unsigned frame_bits(input logic [1:0] len_sel,
                                             input logic par, input logic stop_ext);
    int unsigned n;
    n = 1 + MIN_DATA_BITS + int'(len_sel) + (par ? 1 : 0) + (stop_ext ? 2 : 1);
    return n;
  endfunction

  function automatic int unsigned quiet_bits(input int unsigned periods,
                                             input logic [1:0] len_sel,
                                             input logic par, input logic stop_ext);
    return periods * frame_bits(len_sel, par, stop_ext);
  endfunction
endpackage

// File: rtl/rx_to_limit.sv
module rx_to_limit #(
  parameter int unsigned PERIODS = 4,
  parameter int unsigned CW      = 6
) (
  input  logic [1:0]    len_sel,
  input  logic          par,
  input  logic          stop_ext,
  output logic [CW-1:0] limit
);
  import rx_to_pkg::*;
  always_comb limit = CW'(quiet_bits(PERIODS, len_sel, par, stop_ext));
endmodule

// File: rtl/rx_to_counter.sv
module rx_to_counter #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  logic advance;
  assign advance = !hold && !restart && tick;
  assign hit     = advance && (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (hold || restart)        cnt <= '0;
    else if (advance && cnt < limit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rx_to_flag.sv
module rx_to_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/rx_timeout_det.sv
module rx_timeout_det #(
  parameter int unsigned PERIODS  = 4,
  parameter int unsigned MAX_DATA = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       fifo_nonempty,
  input  logic       wr_pulse,
  input  logic       rd_pulse,
  input  logic       bit_tick,
  input  logic [1:0] char_len,
  input  logic       parity_en,
  input  logic       stop2,
  output logic       timeout
);
  localparam int unsigned MAX_FRAME = 1 + MAX_DATA + 1 + 2;
  localparam int unsigned MAX_LIMIT = PERIODS * MAX_FRAME;
  localparam int unsigned CW        = $clog2(MAX_LIMIT + 1);

  logic [CW-1:0] limit;
  logic [CW-1:0] cnt;
  logic          hold;
  logic          restart;
  logic          hit;

  assign hold    = !fifo_mode || !fifo_nonempty;
  assign restart = wr_pulse || rd_pulse;

  rx_to_limit #(.PERIODS(PERIODS), .CW(CW)) u_limit (
    .len_sel(char_len), .par(parity_en), .stop_ext(stop2), .limit(limit)
  );

  rx_to_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold(hold), .restart(restart),
    .tick(bit_tick), .limit(limit), .cnt(cnt), .hit(hit)
  );

  rx_to_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set(hit), .clr(rd_pulse), .flag(timeout)
  );
endmodule

// File: rtl/rx_timeout_det_chk.sv
module rx_timeout_det_chk #(
  parameter int unsigned CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic          wr_pulse,
  input logic          rd_pulse,
  input logic          bit_tick,
  input logic          timeout,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] limit
);
  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> !timeout);
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !rd_pulse) |=> timeout);
  // R2
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(bit_tick) && !$past(hold));
  // R5
  write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> cnt == '0);
  // R7
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> cnt == '0);
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(limit) |-> cnt <= limit);
endmodule

bind rx_timeout_det rx_timeout_det_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .wr_pulse(wr_pulse),
  .rd_pulse(rd_pulse), .bit_tick(bit_tick), .timeout(timeout),
  .cnt(cnt), .limit(limit)
);

// File: tb/rx_timeout_det_bench.sv
`timescale 1ns/1ps
module rx_timeout_det_bench;
  logic clk = 0, rst_n = 0;
  logic fifo_mode = 0, fifo_nonempty = 0, wr_pulse = 0, rd_pulse = 0, bit_tick = 0;
  logic [1:0] char_len = 2'd3;
  logic parity_en = 1, stop2 = 1;
  logic timeout;

  int checks = 0, fails = 0, cycles = 0;
  int idle = 0;
  bit ref_flag = 0;

  always #10 clk = ~clk;

  rx_timeout_det u_rx_timeout_det (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .fifo_nonempty(fifo_nonempty),
    .wr_pulse(wr_pulse), .rd_pulse(rd_pulse), .bit_tick(bit_tick),
    .char_len(char_len), .parity_en(parity_en), .stop2(stop2), .timeout(timeout)
  );

  // Limit restated from the frame description; 1.5 stop rounds to 2.
  function automatic int ref_limit();
    int stops;
    stops = stop2 ? 2 : 1;
    return 4 * (1 + (5 + char_len) + parity_en + stops);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference model: ticks of silence since the last restart.
  always @(posedge clk) begin
    if (!rst_n) begin
      idle = 0; ref_flag = 0;
    end else begin
      if (rd_pulse) ref_flag = 0;
      if (!fifo_mode || !fifo_nonempty || wr_pulse || rd_pulse) idle = 0;
      else if (bit_tick) begin
        idle = idle + 1;
        if (idle == ref_limit()) ref_flag = 1;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) check(timeout == ref_flag, "R2 per-cycle model", timeout, ref_flag);
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1;
      @(negedge clk) bit_tick = 0;
    end
  endtask
  task automatic do_rd();
    @(negedge clk) rd_pulse = 1;
    @(negedge clk) rd_pulse = 0;
  endtask
  task automatic do_wr();
    @(negedge clk) wr_pulse = 1;
    @(negedge clk) wr_pulse = 0;
  endtask
  task automatic expire(input string tag);
    int lim;
    lim = ref_limit();
    tick(lim - 1);
    check(timeout == 0, tag, timeout, 0);
    tick(1);
    check(timeout == 1, tag, timeout, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(timeout == 0, "R1 reset", timeout, 0);
    rst_n = 1;
    fifo_mode = 1; fifo_nonempty = 1;
    do_wr();
    expire("R2 limit 48");
    tick(5);
    check(timeout == 1, "R9 sticky over ticks", timeout, 1);
    do_wr();
    check(timeout == 1, "R5 write keeps flag", timeout, 1);
    do_rd();
    check(timeout == 0, "R4 read clears", timeout, 0);

    tick(30); do_rd();
    expire("R6 read restarts");
    do_rd();
    tick(40); do_wr();
    expire("R5 write restarts");
    do_rd();

    tick(20);
    @(negedge clk) begin bit_tick = 1; wr_pulse = 1; end
    @(negedge clk) begin bit_tick = 0; wr_pulse = 0; end
    expire("R10 tick with restart");
    do_rd();

    fifo_nonempty = 0;
    tick(100);
    check(timeout == 0, "R7 empty holds", timeout, 0);
    fifo_nonempty = 1;
    expire("R7 resume after empty");
    do_rd();

    tick(20);
    fifo_mode = 0;
    tick(100);
    check(timeout == 0, "R8 non-FIFO holds", timeout, 0);
    fifo_mode = 1;
    expire("R8 resume after mode");
    do_rd();

    for (int k = 0; k < 4; k++) begin
      fifo_nonempty = 0;
      @(negedge clk);
      case (k)
        0: begin char_len = 2'd0; parity_en = 0; stop2 = 0; end
        1: begin char_len = 2'd0; parity_en = 0; stop2 = 1; end
        2: begin char_len = 2'd2; parity_en = 0; stop2 = 0; end
        default: begin char_len = 2'd1; parity_en = 1; stop2 = 0; end
      endcase
      fifo_nonempty = 1;
      @(negedge clk);
      expire($sformatf("R3 format %0d limit %0d", k, ref_limit()));
      do_rd();
    end

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule